// File: doc/BRIEF.md
# Serial DAC Input Latch Receiver

This block is the digital front end of a serial-input audio converter. A bit clock, one serial data line and a latch-enable line come in. On every rising edge of the bit clock, the data bit is pushed into a 20-bit shift register, most significant bit first. The latch-enable line is sampled on the same edges. When it is seen to go from high to low, the shift register contents are copied into the parallel output register. These are the contents from before that edge. A one-cycle update strobe is raised with the new word.

A stream may carry any number of bits before a transfer. Only the last 20 bits shifted in count. The output word is 20-bit two's complement: 0x7FFFF is positive full scale, 0x00000 is bipolar zero, 0xFFFFF is one step below zero and 0x80000 is negative full scale.

A monitor checks how long latch enable stays high and low. It sets a sticky error flag when either minimum is not met. Only reset clears the flag.

Top module: `sdac_latch_rx`

## Requirements
- R1: A synchronous active-low reset clears the parallel word to 0x00000, clears the shift register to zero, drops the update strobe and clears the error flag.
- R2: Each rising edge shifts `ser_din` into the shift register. The bit received earliest among the 20 kept bits ends up in `word_q[19]`, and the latest ends up in `word_q[0]`.
- R3: A stream longer than 20 bits transfers only its last 20 bits, and the leading bits are discarded.
- R4: The parallel word changes, and `upd_stb` is high for exactly one cycle, only after a rising edge that samples `lat_en` low when the previous edge sampled it high. The word holds its value at all other times.
- R5: The data bit sampled on the same edge that detects the latch-enable fall is not part of the transferred word.
- R6: If `lat_en` falls after fewer than MIN_HIGH consecutive high samples (default 2), `rule_err` is set.
- R7: If `lat_en` rises after fewer than MIN_LOW consecutive low samples (default 2), `rule_err` is set. The sample that detected the fall counts as one low sample. Right after reset, the low-time rule counts as satisfied.
- R8: `rule_err` stays set until reset, whatever the later traffic.
- R9: The shift register is not cleared by a transfer, so a stream shorter than 20 bits yields a word whose upper bits are the older bits shifted in before it.
- R10: The four reference codes 0x7FFFF, 0x80000, 0xFFFFF and 0x00000 pass to the output unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_din | input | 1 | Serial data, most significant bit first |
| lat_en | input | 1 | Latch enable; a high-to-low transition triggers the transfer |
| word_q | output | 20 | Latched two's complement word |
| upd_stb | output | 1 | One-cycle pulse with each new word |
| rule_err | output | 1 | Sticky latch-enable timing violation flag |

## Verification
The bench sends the bit on the falling-detect edge opposite to the expected LSB. A design that shifts before transferring would take that bit in and be off by one position. Streams of 28 bits and of 8 bits expose two faults: a design that keeps the first 20 bits instead of the last, and a design that wipes the register on transfer, which would show zeros instead of stale high bits. One-sample high pulses and one-sample low gaps must set the flag, and the flag must survive later clean words. Off-by-one duration counters or a non-sticky flag would miss this. Idle stretches with toggling data check that the word never moves without a fall.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [1:0] {
    LE_STEADY = 2'd0,
    LE_FALL   = 2'd1,
    LE_RISE   = 2'd2
  } le_evt_e;

  // classify a latch-enable transition from two consecutive samples
  function automatic le_evt_e le_classify(input logic prev_s, input logic cur_s);
    if (prev_s && !cur_s)      return LE_FALL;
    else if (!prev_s && cur_s) return LE_RISE;
    else                       return LE_STEADY;
  endfunction

endpackage

// File: rtl/sdac_le_sampler.sv
module sdac_le_sampler
  import sdac_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lat_en,
  output le_evt_e evt
);

  logic le_q;

  always_ff @(posedge clk) begin
    if (!rst_n) le_q <= 1'b0;
    else        le_q <= lat_en;
  end

  // event seen at the coming edge: previous sample vs. current pin
  assign evt = le_classify(le_q, lat_en);

endmodule

// File: rtl/sdac_shift_reg.sv
module sdac_shift_reg #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] shreg_q
);

  function automatic logic [W-1:0] push_lsb(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= push_lsb(shreg_q, din);
  end

endmodule

// File: rtl/sdac_le_monitor.sv
module sdac_le_monitor
  import sdac_pkg::*;
#(
  parameter int unsigned MIN_HIGH = 2,
  parameter int unsigned MIN_LOW  = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lat_en,
  input  le_evt_e evt,
  output logic    hi_short,
  output logic    lo_short,
  output logic    rule_err
);

  localparam int unsigned LIM_MAX = (MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW;
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(MIN_HIGH);
  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(MIN_LOW);

  logic [CNT_W-1:0] hi_run, lo_run;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] lim);
    return (c >= lim) ? lim : c + 1'b1;
  endfunction

  assign hi_short = (hi_run < HI_LIM);
  assign lo_short = (lo_run < LO_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run   <= '0;
      lo_run   <= LO_LIM;
      rule_err <= 1'b0;
    end else begin
      hi_run <= lat_en ? sat_inc(hi_run, HI_LIM) : '0;
      lo_run <= lat_en ? '0 : sat_inc(lo_run, LO_LIM);
      if ((evt == LE_FALL && hi_short) || (evt == LE_RISE && lo_short))
        rule_err <= 1'b1;
    end
  end

endmodule

// File: rtl/sdac_latch_rx.sv
module sdac_latch_rx
  import sdac_pkg::*;
#(
  parameter int unsigned W        = 20,
  parameter int unsigned MIN_HIGH = 2,
  parameter int unsigned MIN_LOW  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_din,
  input  logic         lat_en,
  output logic [W-1:0] word_q,
  output logic         upd_stb,
  output logic         rule_err
);

  le_evt_e      evt;
  logic [W-1:0] shreg_q;
  logic         le_fall, le_rise;
  logic         hi_short, lo_short;

  sdac_le_sampler u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .lat_en (lat_en),
    .evt    (evt)
  );

  sdac_shift_reg #(.W(W)) u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (ser_din),
    .shreg_q (shreg_q)
  );

  sdac_le_monitor #(.MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_en   (lat_en),
    .evt      (evt),
    .hi_short (hi_short),
    .lo_short (lo_short),
    .rule_err (rule_err)
  );

  assign le_fall = (evt == LE_FALL);
  assign le_rise = (evt == LE_RISE);

  // parallel register takes the pre-edge shift contents
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      upd_stb <= 1'b0;
    end else begin
      upd_stb <= le_fall;
      if (le_fall) word_q <= shreg_q;
    end
  end

endmodule

// File: rtl/sdac_latch_rx_chk.sv
module sdac_latch_rx_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lat_en,
  input logic [W-1:0] word_q,
  input logic         upd_stb,
  input logic         rule_err,
  input logic [W-1:0] shreg_q,
  input logic         le_fall,
  input logic         le_rise,
  input logic         hi_short,
  input logic         lo_short
);

  // R4
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(word_q));

  // R4
  stb_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> ($past(lat_en, 2) && !$past(lat_en)));

  // R2
  word_from_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_fall |=> (word_q == $past(shreg_q)));

  // R6
  hi_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_fall && hi_short) |=> rule_err);

  // R7
  lo_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && lo_short) |=> rule_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rule_err |=> rule_err);

endmodule

bind sdac_latch_rx sdac_latch_rx_chk #(.W(W)) u_chk (.*);

// File: tb/sdac_latch_rx_bench.sv
`timescale 1ns/1ps
module sdac_latch_rx_bench;

  localparam int W = 20;
  localparam int MIN_HI = 2;
  localparam int MIN_LO = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_din = 1'b0;
  logic         lat_en = 1'b0;
  logic [W-1:0] word_q;
  logic         upd_stb;
  logic         rule_err;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference
  bit           bits_q[$];
  bit           m_prev_le;
  int           m_hi, m_lo;
  logic [W-1:0] e_word;
  bit           e_stb, e_err;

  always #4 clk = ~clk;

  sdac_latch_rx u_sdac_latch_rx (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .lat_en(lat_en),
    .word_q(word_q), .upd_stb(upd_stb), .rule_err(rule_err)
  );

  task automatic model_reset();
    bits_q.delete();
    for (int i = 0; i < W; i++) bits_q.push_back(1'b0);
    m_prev_le = 1'b0; m_hi = 0; m_lo = MIN_LO;
    e_word = '0; e_stb = 1'b0; e_err = 1'b0;
  endtask

  task automatic model_edge(input bit d, input bit l);
    bit fall, rise;
    fall = m_prev_le && !l;
    rise = !m_prev_le && l;
    e_stb = fall;
    if (fall) begin
      for (int i = 0; i < W; i++)
        e_word[W-1-i] = bits_q[bits_q.size() - W + i];
      if (m_hi < MIN_HI) e_err = 1'b1;
    end
    if (rise && m_lo < MIN_LO) e_err = 1'b1;
    m_hi = l ? m_hi + 1 : 0;
    m_lo = l ? 0 : m_lo + 1;
    bits_q.push_back(d);
    if (bits_q.size() > 64) void'(bits_q.pop_front());
    m_prev_le = l;
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit d, input bit l);
    ser_din = d; lat_en = l;
    if (!rst_n) model_reset(); else model_edge(d, l);
    @(posedge clk);
    @(negedge clk);
    check("word_q", 32'(word_q), 32'(e_word));
    check("upd_stb", 32'(upd_stb), 32'(e_stb));
    check("rule_err", 32'(rule_err), 32'(e_err));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(0, 0); step(0, 0);
    rst_n = 1'b1;
  endtask

  // nb bits of val MSB first with latch enable high, then a fall and one low cycle
  task automatic send(input logic [31:0] val, input int nb, input bit fall_bit);
    for (int i = nb - 1; i >= 0; i--) step(val[i], 1'b1);
    step(fall_bit, 1'b0);
    step(~fall_bit, 1'b0);
  endtask

  initial begin
    #(8ns * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    cur_req = "R1"; do_reset();
    cur_req = "R1"; step(0, 0);

    // R10 reference codes, R5 opposite bit on the fall edge
    cur_req = "R10"; send(32'h7FFFF, W, 1'b0);
    cur_req = "R10"; send(32'h80000, W, 1'b1);
    cur_req = "R10"; send(32'hFFFFF, W, 1'b0);
    cur_req = "R10"; send(32'h00000, W, 1'b1);
    // R2 mixed pattern
    cur_req = "R2";  send(32'hA5C3E, W, 1'b1);
    cur_req = "R5";  send(32'h5A3C1, W, 1'b0);
    // R3 long stream with leading garbage
    cur_req = "R3";  send(32'hF_FF12345, 28, 1'b1);
    cur_req = "R3";  send(32'hA_B0F0F0F, 28, 1'b0);
    // R9 short stream keeps older upper bits
    cur_req = "R9";  send(32'h0000_00C3, 8, 1'b1);
    // R4 idle with toggling data: word must not move
    cur_req = "R4";
    for (int i = 0; i < 12; i++) step(i[0], 1'b0);
    cur_req = "R4";  send(32'h13579, W, 1'b0);

    // R6 one-sample high pulse
    cur_req = "R6";  step(1, 1); step(0, 0); step(0, 0);
    cur_req = "R8";  send(32'h2468A, W, 1'b1);
    cur_req = "R8";  step(1, 0); step(0, 0);
    cur_req = "R1";  do_reset(); step(0, 0);

    // R7 one-sample low gap
    cur_req = "R7";  step(1, 1); step(0, 1); step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    cur_req = "R8";  send(32'h7FFFF, W, 1'b0);
    cur_req = "R1";  do_reset(); step(0, 0);
    cur_req = "R6";  send(32'h00001, W, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule